// File: doc/BRIEF.md
# Hierarchical Quiescence Clock Gate Controller

This block owns the clock enable of a group of downstream devices. Two upstream controllers talk to it over low-power request/accept/deny/active channels of the Q-Channel kind: one channel is driven by the clock-management hierarchy and one by the power-management hierarchy. Each upstream channel may ask the group to go quiescent. The block passes that request down to every full handshake device, collects the answers, and reports acceptance or denial upstream. The gate closes only when both upstream channels hold the group quiescent.

Before it asks the devices to go quiescent, the block waits a programmable number of idle cycles (0 to 255). Any activity during that wait makes it deny the request. Activity comes from two kinds of source: full handshake devices, and extra devices that only report activity. The activity is merged and reflected on both upstream channels. Two override inputs keep the enable high. A synchronised force input does this after a short latency. A scan-test enable does it at once, without passing through any flop.

No data moves through this block, so it has no valid/ready interface. Every pin is a plain level-based handshake or control signal. Each upstream request input, and each group of downstream accept/deny inputs, can be set by a parameter as asynchronous (two-flop synchroniser) or as already synchronous to `clk`. The activity and force inputs are always synchronised.

Top module: `qgate_ctrl`

## Requirements
- R1: After reset (active-low, asynchronous assertion): `clk_en` is 1, both upstream accept_n are 1, both deny outputs are 0, both active outputs are 0, and every `dev_qreq_n` bit is 1.
- R2: `cg_qactive` and `pm_qactive` equal the OR of all `dev_qactive` bits within three cycles. Bits 0..N_DEV-1 belong to full devices and bits N_DEV..N_DEV+N_ACT_ONLY-1 to activity-only devices.
- R3: Raising `entry_dly` by N lengthens the upstream request-to-accept latency by exactly N cycles. `dev_qreq_n` stays all 1 while the delay runs.
- R4: An upstream channel is accepted (accept_n falls) only after every `dev_qreq_n` bit is 0 and every device has accepted. One silent device holds the accept back for as long as it stays silent.
- R5: If any device denies, the requesting channel raises its deny and keeps accept_n at 1. Deny stays high until that channel's request returns to 1, then falls. After that, `dev_qreq_n` returns to all 1.
- R6: Activity seen during the entry delay (from either kind of device) makes the request end in a deny, and `dev_qreq_n` never goes low for that request.
- R7: A channel that requests quiescence while the devices are already quiescent for the other channel is accepted within six cycles, with no new downstream handshake.
- R8: `clk_en` is 0 only while both upstream channels are accepted and no override is active. It falls within three cycles of the second acceptance.
- R9: On exit, `clk_en` is 1 for at least one cycle before any `dev_qreq_n` bit rises. An upstream accept_n rises only after every device has returned to run.
- R10: A channel that withdraws its request while the other channel is still accepted keeps its accept_n at 0 until the other channel also withdraws and the devices are back in run. `clk_en` is 1 during that time.
- R11: `clk_force` held high makes `clk_en` 1 within four cycles. After release, gating resumes if both channels are still accepted.
- R12: `test_cg_en` high makes `clk_en` 1 without waiting for a clock edge.
- R13: No upstream channel ever shows deny high together with accept_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; asynchronous assertion, synchronous release |
| cg_qreq_n | input | 1 | Clock-hierarchy channel request, low asks for quiescence |
| cg_qaccept_n | output | 1 | Clock-hierarchy channel accept, low when quiescence is granted |
| cg_qdeny | output | 1 | Clock-hierarchy channel deny |
| cg_qactive | output | 1 | Merged device activity toward the clock hierarchy |
| pm_qreq_n | input | 1 | Power-hierarchy channel request, low asks for quiescence |
| pm_qaccept_n | output | 1 | Power-hierarchy channel accept |
| pm_qdeny | output | 1 | Power-hierarchy channel deny |
| pm_qactive | output | 1 | Merged device activity toward the power hierarchy |
| dev_qreq_n | output | N_DEV | Request to each full device, low asks for quiescence |
| dev_qaccept_n | input | N_DEV | Accept from each full device |
| dev_qdeny | input | N_DEV | Deny from each full device |
| dev_qactive | input | N_DEV+N_ACT_ONLY | Activity from full and activity-only devices |
| entry_dly | input | DLY_W | Idle cycles to wait before the downstream request; quasi-static |
| clk_force | input | 1 | Asynchronous force-on of the clock enable |
| test_cg_en | input | 1 | Scan-test gate enable, acts without a clock edge |
| clk_en | output | 1 | Enable for the external clock gate cell |

## Verification
A wrong downstream sequencer state shows up at the ports within a few cycles. It shows as an upstream accept while a device is still silent, as requests released before the enable is back, or as a deny that lets go before the request is withdrawn. A stuck delay counter changes the request-to-accept latency by a fixed number of cycles, so comparing latencies for different delay values exposes it on the first request. A lost per-channel state shows on the enable. Either the gate closes with only one channel accepted, or an exit completes while the other channel still holds the group quiescent. Random mixes of channel order, device denials and short delays reach these states from many histories.

// File: rtl/qgate_pkg.sv
`timescale 1ns/1ps
package qgate_pkg;

  // Downstream sequencer states
  typedef enum logic [2:0] {
    DS_RUN,     // devices running, requests high
    DS_DELAY,   // counting idle hysteresis cycles
    DS_ENTER,   // requests low, collecting answers
    DS_QUIET,   // every device accepted
    DS_DENIED,  // a device or activity refused entry
    DS_WAKE,    // enable reopened, requests still low
    DS_EXIT     // requests high, collecting run answers
  } ds_state_e;

  // Per upstream channel states
  typedef enum logic [2:0] {
    UC_RUN,
    UC_WAIT,
    UC_ACC,
    UC_DENY,
    UC_EXIT
  } uc_state_e;

endpackage

// File: rtl/qgate_sync.sv
`timescale 1ns/1ps
module qgate_sync #(
  parameter int unsigned      W       = 1,
  parameter bit               ASYNC   = 1'b1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (ASYNC) begin : g_async
      logic [W-1:0] meta_q;
      logic [W-1:0] safe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= RST_VAL;
          safe_q <= RST_VAL;
        end else begin
          meta_q <= d;
          safe_q <= meta_q;
        end
      end
      assign q = safe_q;
    end else begin : g_bypass
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/qgate_up_chan.sv
`timescale 1ns/1ps
module qgate_up_chan
  import qgate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_n,
  input  ds_state_e ds,
  output uc_state_e st,
  output logic      accept_n,
  output logic      deny
);

  uc_state_e nxt;

  always_comb begin
    nxt = st;
    case (st)
      UC_RUN:  if (!req_n) nxt = UC_WAIT;
      UC_WAIT: begin
        if (ds == DS_QUIET)       nxt = UC_ACC;
        else if (ds == DS_DENIED) nxt = UC_DENY;
      end
      UC_ACC:  if (req_n) nxt = UC_EXIT;
      UC_DENY: if (req_n) nxt = UC_RUN;
      UC_EXIT: if (ds == DS_RUN) nxt = UC_RUN;
      default: nxt = UC_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= UC_RUN;
      accept_n <= 1'b1;
      deny     <= 1'b0;
    end else begin
      st       <= nxt;
      accept_n <= !((nxt == UC_ACC) || (nxt == UC_EXIT));
      deny     <= (nxt == UC_DENY);
    end
  end

endmodule

// File: rtl/qgate_down_seq.sv
`timescale 1ns/1ps
module qgate_down_seq
  import qgate_pkg::*;
#(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_wait,
  input  logic             any_hold,
  input  logic             any_block,
  input  logic             act_any,
  input  logic [DLY_W-1:0] dly,
  input  logic [N_DEV-1:0] dev_acc_n,
  input  logic [N_DEV-1:0] dev_deny,
  output ds_state_e        ds,
  output logic [N_DEV-1:0] dev_req_n
);

  localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

  ds_state_e        nxt;
  logic [DLY_W-1:0] cnt_q;
  logic             req_q;
  logic             all_acc;
  logic             all_run;
  logic             some_deny;

  assign all_acc   = (dev_acc_n == '0);
  assign all_run   = (dev_acc_n == '1);
  assign some_deny = |dev_deny;

  always_comb begin
    nxt = ds;
    case (ds)
      DS_RUN:    if (any_wait) nxt = DS_DELAY;
      DS_DELAY: begin
        if (act_any)           nxt = DS_DENIED;
        else if (cnt_q == '0)  nxt = DS_ENTER;
      end
      DS_ENTER: begin
        if (some_deny)         nxt = DS_DENIED;
        else if (all_acc)      nxt = DS_QUIET;
      end
      DS_QUIET:  if (!any_hold)  nxt = DS_WAKE;
      DS_DENIED: if (!any_block) nxt = DS_EXIT;
      DS_WAKE:   nxt = DS_EXIT;
      DS_EXIT:   if (all_run && !some_deny) nxt = DS_RUN;
      default:   nxt = DS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds    <= DS_RUN;
      cnt_q <= '0;
      req_q <= 1'b1;
    end else begin
      ds <= nxt;
      if (ds == DS_RUN && nxt == DS_DELAY)
        cnt_q <= dly;
      else if (ds == DS_DELAY && cnt_q != '0)
        cnt_q <= cnt_q - DLY_ONE;
      // a denial keeps whatever level the requests already had
      if (nxt == DS_ENTER)
        req_q <= 1'b0;
      else if (nxt == DS_EXIT)
        req_q <= 1'b1;
    end
  end

  assign dev_req_n = {N_DEV{req_q}};

endmodule

// File: rtl/qgate_ctrl.sv
`timescale 1ns/1ps
module qgate_ctrl
  import qgate_pkg::*;
#(
  parameter int unsigned N_DEV      = 4,
  parameter int unsigned N_ACT_ONLY = 2,
  parameter int unsigned DLY_W      = 8,
  parameter bit          CG_ASYNC   = 1'b1,
  parameter bit          PM_ASYNC   = 1'b1,
  parameter bit          DEV_ASYNC  = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cg_qreq_n,
  output logic                        cg_qaccept_n,
  output logic                        cg_qdeny,
  output logic                        cg_qactive,
  input  logic                        pm_qreq_n,
  output logic                        pm_qaccept_n,
  output logic                        pm_qdeny,
  output logic                        pm_qactive,
  output logic [N_DEV-1:0]            dev_qreq_n,
  input  logic [N_DEV-1:0]            dev_qaccept_n,
  input  logic [N_DEV-1:0]            dev_qdeny,
  input  logic [N_DEV+N_ACT_ONLY-1:0] dev_qactive,
  input  logic [DLY_W-1:0]            entry_dly,
  input  logic                        clk_force,
  input  logic                        test_cg_en,
  output logic                        clk_en
);

  localparam int NUP   = 2;
  localparam int N_ACT = N_DEV + N_ACT_ONLY;

  ds_state_e        ds;
  uc_state_e        uc_st [NUP];
  logic [NUP-1:0]   up_req_raw;
  logic [NUP-1:0]   up_req_s;
  logic [NUP-1:0]   up_acc_n;
  logic [NUP-1:0]   up_deny;
  logic [NUP-1:0]   is_wait;
  logic [NUP-1:0]   is_acc;
  logic [NUP-1:0]   is_deny;
  logic [N_DEV-1:0] dev_acc_s;
  logic [N_DEV-1:0] dev_deny_s;
  logic [N_ACT-1:0] act_s;
  logic             act_any;
  logic             force_s;
  logic             clk_en_q;

  assign up_req_raw = {pm_qreq_n, cg_qreq_n};

  generate
    for (genvar i = 0; i < NUP; i++) begin : g_up
      qgate_sync #(
        .W      (1),
        .ASYNC  ((i == 0) ? CG_ASYNC : PM_ASYNC),
        .RST_VAL(1'b1)
      ) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (up_req_raw[i]),
        .q    (up_req_s[i])
      );

      qgate_up_chan u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (up_req_s[i]),
        .ds      (ds),
        .st      (uc_st[i]),
        .accept_n(up_acc_n[i]),
        .deny    (up_deny[i])
      );

      assign is_wait[i] = (uc_st[i] == UC_WAIT);
      assign is_acc[i]  = (uc_st[i] == UC_ACC);
      assign is_deny[i] = (uc_st[i] == UC_DENY);
    end
  endgenerate

  qgate_sync #(.W(N_DEV), .ASYNC(DEV_ASYNC), .RST_VAL('1)) u_acc_sync (
    .clk(clk), .rst_n(rst_n), .d(dev_qaccept_n), .q(dev_acc_s)
  );

  qgate_sync #(.W(N_DEV), .ASYNC(DEV_ASYNC), .RST_VAL('0)) u_deny_sync (
    .clk(clk), .rst_n(rst_n), .d(dev_qdeny), .q(dev_deny_s)
  );

  qgate_sync #(.W(N_ACT), .ASYNC(1'b1), .RST_VAL('0)) u_act_sync (
    .clk(clk), .rst_n(rst_n), .d(dev_qactive), .q(act_s)
  );

  qgate_sync #(.W(1), .ASYNC(1'b1), .RST_VAL(1'b0)) u_force_sync (
    .clk(clk), .rst_n(rst_n), .d(clk_force), .q(force_s)
  );

  assign act_any = |act_s;

  qgate_down_seq #(.N_DEV(N_DEV), .DLY_W(DLY_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_wait (|is_wait),
    .any_hold (|(is_wait | is_acc)),
    .any_block(|(is_wait | is_deny)),
    .act_any  (act_any),
    .dly      (entry_dly),
    .dev_acc_n(dev_acc_s),
    .dev_deny (dev_deny_s),
    .ds       (ds),
    .dev_req_n(dev_qreq_n)
  );

  // Enable closes only with the group quiet and both channels accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_en_q <= 1'b1;
    else        clk_en_q <= force_s || !((ds == DS_QUIET) && (&is_acc));
  end

  // Scan enable bypasses every flop so shift clocks always reach the devices.
  assign clk_en = clk_en_q | test_cg_en;

  assign cg_qaccept_n = up_acc_n[0];
  assign pm_qaccept_n = up_acc_n[1];
  assign cg_qdeny     = up_deny[0];
  assign pm_qdeny     = up_deny[1];
  assign cg_qactive   = act_any;
  assign pm_qactive   = act_any;

endmodule

// File: rtl/qgate_ctrl_chk.sv
`timescale 1ns/1ps
module qgate_ctrl_chk #(
  parameter int unsigned N_DEV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cg_qreq_n,
  input logic             cg_qaccept_n,
  input logic             cg_qdeny,
  input logic             pm_qreq_n,
  input logic             pm_qaccept_n,
  input logic             pm_qdeny,
  input logic [N_DEV-1:0] dev_qreq_n,
  input logic [N_DEV-1:0] dev_qaccept_n,
  input logic             clk_force,
  input logic             test_cg_en,
  input logic             clk_en
);

  assert_gate_needs_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (!cg_qaccept_n && !pm_qaccept_n));

  assert_accept_after_devices_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cg_qaccept_n) || $fell(pm_qaccept_n)) |-> (dev_qreq_n == '0));

  assert_exit_after_devices_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cg_qaccept_n) || $rose(pm_qaccept_n)) |-> (dev_qaccept_n == '1));

  assert_enable_before_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_qreq_n[0]) |-> $past(clk_en));

  assert_cg_deny_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_qdeny && !cg_qreq_n) |=> cg_qdeny);

  assert_pm_deny_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_qdeny && !pm_qreq_n) |=> pm_qdeny);

  assert_cg_no_both_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(cg_qdeny && !cg_qaccept_n));

  assert_pm_no_both_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_qdeny && !pm_qaccept_n));

  assert_force_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_force && $past(clk_force) && $past(clk_force, 2) && $past(clk_force, 3)) |-> clk_en);

  assert_test_opens_R12: assert property (@(posedge clk) disable iff (!rst_n)
    test_cg_en |-> clk_en);

endmodule

bind qgate_ctrl qgate_ctrl_chk #(.N_DEV(N_DEV)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cg_qreq_n    (cg_qreq_n),
  .cg_qaccept_n (cg_qaccept_n),
  .cg_qdeny     (cg_qdeny),
  .pm_qreq_n    (pm_qreq_n),
  .pm_qaccept_n (pm_qaccept_n),
  .pm_qdeny     (pm_qdeny),
  .dev_qreq_n   (dev_qreq_n),
  .dev_qaccept_n(dev_qaccept_n),
  .clk_force    (clk_force),
  .test_cg_en   (test_cg_en),
  .clk_en       (clk_en)
);

// File: tb/qgate_ctrl_tb.sv
`timescale 1ns/1ps
module qgate_ctrl_tb;

  localparam int N = 4;
  localparam int A = 2;
  localparam int BOUND = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cg_req_n = 1'b1, pm_req_n = 1'b1;
  logic cg_acc_n, cg_deny, cg_act, pm_acc_n, pm_deny, pm_act;
  logic [N-1:0] dq_n;
  logic [N-1:0] d_acc_n = '1;
  logic [N-1:0] d_deny = '0;
  logic [N+A-1:0] d_act = '0;
  logic [7:0] dly = '0;
  logic force_on = 1'b0, test_en = 1'b0;
  logic clk_en;

  logic [N-1:0] deny_mask = '0;
  logic [N-1:0] hold_mask = '0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qgate_ctrl #(.N_DEV(N), .N_ACT_ONLY(A)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cg_qreq_n(cg_req_n), .cg_qaccept_n(cg_acc_n), .cg_qdeny(cg_deny), .cg_qactive(cg_act),
    .pm_qreq_n(pm_req_n), .pm_qaccept_n(pm_acc_n), .pm_qdeny(pm_deny), .pm_qactive(pm_act),
    .dev_qreq_n(dq_n), .dev_qaccept_n(d_acc_n), .dev_qdeny(d_deny), .dev_qactive(d_act),
    .entry_dly(dly), .clk_force(force_on), .test_cg_en(test_en), .clk_en(clk_en)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_enable(input bit a0, input bit a1, input bit frc, input bit tst);
    return frc || tst || !(a0 && a1);
  endfunction

  function automatic logic acc_of(input int ch);
    return (ch == 0) ? cg_acc_n : pm_acc_n;
  endfunction

  function automatic logic deny_of(input int ch);
    return (ch == 0) ? cg_deny : pm_deny;
  endfunction

  task automatic set_req(input int ch, input logic v);
    if (ch == 0) cg_req_n = v; else pm_req_n = v;
  endtask

  // Device model: answers one negedge after it sees a request change
  initial forever begin
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (!rst_n || dq_n[i]) begin
        d_acc_n[i] = 1'b1;
        d_deny[i]  = 1'b0;
      end else if (d_acc_n[i] && !d_deny[i] && !hold_mask[i]) begin
        if (deny_mask[i]) d_deny[i] = 1'b1;
        else              d_acc_n[i] = 1'b0;
      end
    end
  end

  // Port monitors for R8 and R9
  logic prev_req0 = 1'b1;
  logic prev_en = 1'b1;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (dq_n[0] && !prev_req0)
        chk("R9", "enable before release", prev_en, 1);
      if (!clk_en)
        chk("R8", "gate closed with both accepted", {cg_acc_n, pm_acc_n}, 0);
    end
    prev_req0 = dq_n[0];
    prev_en   = clk_en;
  end

  task automatic enter(input int ch, output bit denied, output int lat);
    set_req(ch, 1'b0);
    lat = 0;
    denied = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (acc_of(ch) == 1'b0) begin denied = 0; break; end
      if (deny_of(ch) == 1'b1) begin denied = 1; break; end
      if (lat > BOUND) begin chk("R4", "entry timeout", lat, 0); break; end
    end
  endtask

  task automatic withdraw(input int ch);
    int t = 0;
    set_req(ch, 1'b1);
    while (deny_of(ch) && t < BOUND) begin @(negedge clk); t++; end
    chk("R5", "deny dropped after withdraw", deny_of(ch), 0);
    t = 0;
    while (dq_n != '1 && t < BOUND) begin @(negedge clk); t++; end
    chk("R5", "device requests back to run", dq_n, {N{1'b1}});
  endtask

  task automatic leave_all(input bit l0, input bit l1);
    int t = 0;
    if (l0) cg_req_n = 1'b1;
    if (l1) pm_req_n = 1'b1;
    while (((l0 && cg_acc_n == 1'b0) || (l1 && pm_acc_n == 1'b0)) && t < BOUND) begin
      @(negedge clk); t++;
    end
    chk("R9", "exit completes", {l0 ? cg_acc_n : 1'b1, l1 ? pm_acc_n : 1'b1}, 3);
    chk("R9", "devices running after exit", dq_n, {N{1'b1}});
  endtask

  initial begin
    bit den;
    int lat0, lat, t;
    bit acc0, acc1;
    bit saw_low;
    int seed_unused;
    seed_unused = $urandom(32'd20240611);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "clk_en", clk_en, 1);
    chk("R1", "accept_n", {cg_acc_n, pm_acc_n}, 3);
    chk("R1", "deny", {cg_deny, pm_deny}, 0);
    chk("R1", "active", {cg_act, pm_act}, 0);
    chk("R1", "dev_qreq_n", dq_n, {N{1'b1}});

    // R2 activity merge, random and directed
    for (int k = 0; k < 10; k++) begin
      logic [N+A-1:0] pat;
      pat = (k == 0) ? (N+A)'(1) << N : (k == 1) ? '0 : (N+A)'($urandom);
      d_act = pat;
      repeat (4) @(negedge clk);
      chk("R2", "cg_qactive", cg_act, |pat);
      chk("R2", "pm_qactive", pm_act, |pat);
    end
    d_act = '0;
    repeat (4) @(negedge clk);

    // R3 hysteresis latency versus zero delay
    dly = 8'd0;
    enter(0, den, lat0);
    chk("R4", "accepted", den, 0);
    chk("R4", "devices requested", dq_n, 0);
    chk("R8", "gate open with one channel", clk_en, 1);
    leave_all(1, 0);
    for (int k = 0; k < 4; k++) begin
      int nd;
      nd = $urandom_range(1, 120);
      dly = 8'(nd);
      enter(0, den, lat);
      chk("R3", "latency growth", lat - lat0, nd);
      leave_all(1, 0);
    end
    dly = 8'd255;
    enter(0, den, lat);
    chk("R3", "latency growth at 255", lat - lat0, 255);
    leave_all(1, 0);

    // R3 requests stay high during the delay
    dly = 8'd50;
    cg_req_n = 1'b0;
    repeat (30) @(negedge clk);
    chk("R3", "requests high during delay", dq_n, {N{1'b1}});
    chk("R3", "no accept during delay", cg_acc_n, 1);
    t = 0;
    while (cg_acc_n && t < BOUND) begin @(negedge clk); t++; end
    chk("R4", "accept after delay", cg_acc_n, 0);
    leave_all(1, 0);

    // R4 silent device holds accept back
    dly = 8'd0;
    hold_mask = 4'b0100;
    cg_req_n = 1'b0;
    repeat (40) @(negedge clk);
    chk("R4", "no accept while device silent", cg_acc_n, 1);
    chk("R4", "requests issued", dq_n, 0);
    hold_mask = '0;
    t = 0;
    while (cg_acc_n && t < BOUND) begin @(negedge clk); t++; end
    chk("R4", "accept once device answers", cg_acc_n, 0);

    // R7 second channel joins an already quiet group
    enter(1, den, lat);
    chk("R7", "second channel accepted", den, 0);
    chk("R7", "fast accept", lat <= 6, 1);
    repeat (3) @(negedge clk);
    chk("R8", "gate closed", clk_en, exp_enable(1, 1, 0, 0));

    // R11 force
    force_on = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "forced open", clk_en, 1);
    force_on = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11", "gating resumes", clk_en, 0);

    // R12 test enable acts without a clock edge
    test_en = 1'b1;
    #1;
    chk("R12", "test opens at once", clk_en, 1);
    test_en = 1'b0;
    #1;
    chk("R12", "test release", clk_en, 0);

    // R10 one channel leaves while the other stays
    cg_req_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R10", "exit held while other quiet", cg_acc_n, 0);
    chk("R10", "gate open during held exit", clk_en, 1);
    chk("R10", "devices still quiet", dq_n, 0);
    leave_all(1, 1);

    // R5 device denial
    deny_mask = 4'b0010;
    enter(0, den, lat);
    chk("R5", "deny raised", den, 1);
    repeat (20) @(negedge clk);
    chk("R5", "deny held", cg_deny, 1);
    chk("R13", "accept stays high with deny", cg_acc_n, 1);
    withdraw(0);
    deny_mask = '0;

    // R6 activity during the delay
    dly = 8'd60;
    saw_low = 0;
    cg_req_n = 1'b0;
    repeat (15) @(negedge clk);
    d_act = (N+A)'(1) << (N + 1);
    t = 0;
    while (!cg_deny && t < BOUND) begin
      @(negedge clk); t++;
      if (dq_n != '1) saw_low = 1;
    end
    chk("R6", "deny on activity", cg_deny, 1);
    chk("R6", "devices never requested", saw_low, 0);
    chk("R6", "no accept", cg_acc_n, 1);
    withdraw(0);
    d_act = '0;
    repeat (4) @(negedge clk);

    // Random channel mixes
    acc0 = 0; acc1 = 0;
    for (int it = 0; it < 60; it++) begin
      int ch;
      bit exp_den;
      bit other;
      ch = $urandom_range(0, 1);
      other = (ch == 0) ? acc1 : acc0;
      if ((ch == 0) ? acc0 : acc1) begin
        if (other) begin leave_all(1, 1); acc0 = 0; acc1 = 0; end
        else begin leave_all(ch == 0, ch == 1); if (ch == 0) acc0 = 0; else acc1 = 0; end
      end else begin
        deny_mask = ($urandom_range(0, 3) == 0) ? N'(1) << $urandom_range(0, N-1) : '0;
        dly = 8'($urandom_range(0, 7));
        exp_den = other ? 1'b0 : (deny_mask != '0);
        enter(ch, den, lat);
        chk(other ? "R7" : "R5", "random entry outcome", den, exp_den);
        if (den) withdraw(ch);
        else if (ch == 0) acc0 = 1;
        else acc1 = 1;
      end
      repeat (4) @(negedge clk);
      chk("R8", "random enable level", clk_en, exp_enable(acc0, acc1, 0, 0));
    end
    deny_mask = '0;
    leave_all(acc0, acc1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule